// File: doc/BRIEF.md
# PLL Divider Configuration Controller

This block holds the divider settings that steer a frequency synthesizer's PLL. The settings are a 10-bit feedback divider, a 3-bit output divider for bank A, a 1-bit output divider for bank B and a 1-bit prescaler. Two copies are kept. The active copy drives the PLL. The shadow copy is the pair of byte-wide registers that a host bus interface reads and writes: a low byte and a high byte.

A mode pin selects where the settings come from. With the pin low, in pin mode, the active copy follows the divider pins on every clock, and the shadow pair mirrors them as a read-only view. With the pin high, in host mode, the pins are ignored. The host writes the shadow pair and then issues commands through a write-only command byte. One command copies the shadow into the active copy. Another copies the active copy back into the shadow. Two more step the feedback divider up or down by one. The PLL lock flag is folded into the high byte so the host can read it.

Top module: `pll_divcfg_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the active and shadow copies are loaded with the reset parameters (feedback divider 200, A divider 1, B divider 0, prescaler 0).
- R2: When `serial_mode` is 0 at a clock edge, the active outputs take the divider pin values at that edge, including the first edge after a change from host mode. The new values are visible in the following cycle.
- R3: When `serial_mode` is 0, the shadow pair mirrors the pins at the same edge. Register writes and all commands are ignored.
- R4: When `serial_mode` goes from 0 to 1, both copies keep their last values, and later pin changes have no effect.
- R5: The low byte (address 0x00) reads as feedback divider bits 7:0. The high byte (address 0x01) reads as {lock, prescaler, B divider, A divider[2:0], feedback divider[9:8]} from bit 7 down to bit 0. Bit 7 shows `lock_in`, and writing it has no effect. `reg_rd_data` is registered, so it reflects the address and state one cycle later. Any other address, including 0x F0, reads 0.
- R6: In host mode, a write to 0x00 or 0x01 changes only the shadow copy. The active outputs keep their values.
- R7: In host mode, a write to 0xF0 decodes bits 3:0 as follows: 0001 increments the active feedback divider, 0010 decrements it, 0100 loads the active copy from the shadow, and 1000 loads the shadow from the active copy. Bits 7:4 are ignored, and the result is visible one cycle after the write.
- R8: An increment at 1023 and a decrement at 0 leave the feedback divider unchanged.
- R9: A command nibble that does not have exactly one of these four bits set changes nothing.
- R10: An increment or decrement leaves the shadow pair unchanged until a shadow-load command (1000) is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 0 = pin mode, 1 = host mode |
| pin_fb_div | input | 10 | Feedback divider pins |
| pin_div_a | input | 3 | Bank A divider pins |
| pin_div_b | input | 1 | Bank B divider pin |
| pin_prescale | input | 1 | Prescaler pin |
| lock_in | input | 1 | PLL lock flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Write address |
| reg_wr_data | input | 8 | Write data |
| reg_rd_addr | input | 8 | Read address |
| reg_rd_data | output | 8 | Registered read data |
| act_fb_div | output | 10 | Active feedback divider |
| act_div_a | output | 3 | Active bank A divider |
| act_div_b | output | 1 | Active bank B divider |
| act_prescale | output | 1 | Active prescaler |

## Verification
The assertions assume a write strobe lasts a single cycle and carries one address. They also assume that `serial_mode` and the divider pins are synchronous to `clk`. Some checks take a cycle with no write as the point where the active copy must hold. The stimulus changes every input on the falling edge and pulses `reg_wr_en` for exactly one cycle per access. It switches mode only in cycles with no write, so every property sees settled inputs whose meaning is unambiguous.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  parameter int FB_W   = 10;
  parameter int DIVA_W = 3;
  parameter int BYTE_W = 8;
  localparam int FB_HI_W = FB_W - BYTE_W;
  localparam logic [FB_W-1:0] FB_MAX = {FB_W{1'b1}};

  typedef struct packed {
    logic              pre;
    logic              divb;
    logic [DIVA_W-1:0] diva;
    logic [FB_W-1:0]   fb;
  } div_cfg_t;

  typedef struct packed {
    logic inc;
    logic dec;
    logic load;
    logic get;
    logic wr_lo;
    logic wr_hi;
  } ctl_req_t;
endpackage

// File: rtl/pll_cmd_decode.sv
module pll_cmd_decode
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0
) (
  input  logic              host_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        op_nib,
  output ctl_req_t          req
);
  logic valid_op;
  logic hit_cmd;

  always_comb begin
    valid_op  = ($countones(op_nib) == 1);
    hit_cmd   = host_en && wr_en && (wr_addr == CMD_ADDR) && valid_op;
    req.inc   = hit_cmd && op_nib[0];
    req.dec   = hit_cmd && op_nib[1];
    req.load  = hit_cmd && op_nib[2];
    req.get   = hit_cmd && op_nib[3];
    req.wr_lo = host_en && wr_en && (wr_addr == LO_ADDR);
    req.wr_hi = host_en && wr_en && (wr_addr == HI_ADDR);
  end
endmodule

// File: rtl/pll_fb_stepper.sv
module pll_fb_stepper
  import pll_cfg_pkg::*;
#(
  parameter int W = FB_W
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt = cur;
    if (up && (cur != TOP))
      nxt = cur + ONE;
    else if (down && (cur != '0))
      nxt = cur - ONE;
  end
endmodule

// File: rtl/pll_shadow_bank.sv
module pll_shadow_bank
  import pll_cfg_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_en,
  input  div_cfg_t          pin_cfg,
  input  div_cfg_t          act_cfg,
  input  ctl_req_t          req,
  input  logic [BYTE_W-1:0] wr_data,
  output div_cfg_t          shd_cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_cfg <= RST_CFG;
    end else if (!host_en) begin
      shd_cfg <= pin_cfg;
    end else if (req.get) begin
      shd_cfg <= act_cfg;
    end else begin
      if (req.wr_lo)
        shd_cfg.fb[BYTE_W-1:0] <= wr_data;
      if (req.wr_hi) begin
        shd_cfg.fb[FB_W-1:BYTE_W] <= wr_data[FB_HI_W-1:0];
        shd_cfg.diva <= wr_data[FB_HI_W +: DIVA_W];
        shd_cfg.divb <= wr_data[FB_HI_W+DIVA_W];
        shd_cfg.pre  <= wr_data[FB_HI_W+DIVA_W+1];
      end
    end
  end
endmodule

// File: rtl/pll_active_bank.sv
module pll_active_bank
  import pll_cfg_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     host_en,
  input  div_cfg_t pin_cfg,
  input  div_cfg_t shd_cfg,
  input  ctl_req_t req,
  output div_cfg_t act_cfg
);
  logic [FB_W-1:0] fb_step;

  pll_fb_stepper #(.W(FB_W)) u_step (
    .cur  (act_cfg.fb),
    .up   (req.inc),
    .down (req.dec),
    .nxt  (fb_step)
  );

  always_ff @(posedge clk) begin
    if (rst)
      act_cfg <= RST_CFG;
    else if (!host_en)
      act_cfg <= pin_cfg;
    else if (req.load)
      act_cfg <= shd_cfg;
    else if (req.inc || req.dec)
      act_cfg.fb <= fb_step;
  end
endmodule

// File: rtl/pll_divcfg_ctrl.sv
module pll_divcfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0,
  parameter logic [FB_W-1:0]   RST_FB   = 10'd200,
  parameter logic [DIVA_W-1:0] RST_DIVA = 3'd1,
  parameter logic              RST_DIVB = 1'b0,
  parameter logic              RST_PRE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  input  logic [FB_W-1:0]   pin_fb_div,
  input  logic [DIVA_W-1:0] pin_div_a,
  input  logic              pin_div_b,
  input  logic              pin_prescale,
  input  logic              lock_in,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [BYTE_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [BYTE_W-1:0] reg_rd_data,
  output logic [FB_W-1:0]   act_fb_div,
  output logic [DIVA_W-1:0] act_div_a,
  output logic              act_div_b,
  output logic              act_prescale
);
  localparam div_cfg_t RST_CFG = '{pre: RST_PRE, divb: RST_DIVB, diva: RST_DIVA, fb: RST_FB};

  div_cfg_t pin_cfg;
  div_cfg_t act_cfg;
  div_cfg_t shd_cfg;
  ctl_req_t req;
  logic [BYTE_W-1:0] rd_mux;

  assign pin_cfg = '{pre: pin_prescale, divb: pin_div_b, diva: pin_div_a, fb: pin_fb_div};

  pll_cmd_decode #(
    .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .host_en (serial_mode),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .op_nib  (reg_wr_data[3:0]),
    .req     (req)
  );

  pll_shadow_bank #(.RST_CFG(RST_CFG)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .host_en (serial_mode),
    .pin_cfg (pin_cfg),
    .act_cfg (act_cfg),
    .req     (req),
    .wr_data (reg_wr_data),
    .shd_cfg (shd_cfg)
  );

  pll_active_bank #(.RST_CFG(RST_CFG)) u_active (
    .clk     (clk),
    .rst     (rst),
    .host_en (serial_mode),
    .pin_cfg (pin_cfg),
    .shd_cfg (shd_cfg),
    .req     (req),
    .act_cfg (act_cfg)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_rd_addr == LO_ADDR)
      rd_mux = shd_cfg.fb[BYTE_W-1:0];
    else if (reg_rd_addr == HI_ADDR)
      rd_mux = {lock_in, shd_cfg.pre, shd_cfg.divb, shd_cfg.diva, shd_cfg.fb[FB_W-1:BYTE_W]};
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rd_data <= '0;
    else
      reg_rd_data <= rd_mux;
  end

  assign act_fb_div   = act_cfg.fb;
  assign act_div_a    = act_cfg.diva;
  assign act_div_b    = act_cfg.divb;
  assign act_prescale = act_cfg.pre;
endmodule

// File: rtl/pll_divcfg_checker.sv
module pll_divcfg_checker
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic              serial_mode,
  input logic [FB_W-1:0]   pin_fb_div,
  input logic [DIVA_W-1:0] pin_div_a,
  input logic              lock_in,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [BYTE_W-1:0] reg_wr_data,
  input logic [ADDR_W-1:0] reg_rd_addr,
  input logic [BYTE_W-1:0] reg_rd_data,
  input logic [FB_W-1:0]   act_fb_div,
  input logic [DIVA_W-1:0] act_div_a
);
  logic cmd_wr;
  assign cmd_wr = serial_mode && reg_wr_en && (reg_wr_addr == CMD_ADDR);

  // R2: pin mode copies pins into the active outputs
  assert_pin_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |=> (act_fb_div == $past(pin_fb_div)) && (act_div_a == $past(pin_div_a)));

  // R4: entering host mode with no write keeps the active copy
  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(serial_mode) && !reg_wr_en) |=> $stable(act_fb_div) && $stable(act_div_a));

  // R5: lock flag is shown in bit 7 of the high byte
  assert_lock_view_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_addr == HI_ADDR) |=> (reg_rd_data[BYTE_W-1] == $past(lock_in)));

  // R8: increment at the top value saturates
  assert_inc_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (reg_wr_data[3:0] == 4'b0001) && (act_fb_div == FB_MAX)) |=> $stable(act_fb_div));

  // R8: decrement at zero saturates
  assert_dec_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (reg_wr_data[3:0] == 4'b0010) && (act_fb_div == '0)) |=> $stable(act_fb_div));

  // R7: increment below the top adds one
  assert_inc_step_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (reg_wr_data[3:0] == 4'b0001) && (act_fb_div != FB_MAX))
      |=> (act_fb_div == $past(act_fb_div) + 10'd1));

  // R9: a nibble that is not one-hot changes nothing
  assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && ($countones(reg_wr_data[3:0]) != 1)) |=> $stable(act_fb_div) && $stable(act_div_a));
endmodule

bind pll_divcfg_ctrl pll_divcfg_checker #(
  .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .serial_mode (serial_mode),
  .pin_fb_div  (pin_fb_div),
  .pin_div_a   (pin_div_a),
  .lock_in     (lock_in),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .reg_rd_addr (reg_rd_addr),
  .reg_rd_data (reg_rd_data),
  .act_fb_div  (act_fb_div),
  .act_div_a   (act_div_a)
);

// File: tb/pll_divcfg_ctrl_bench.sv
`timescale 1ns/1ps
module pll_divcfg_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serial_mode = 1'b1;
  logic [9:0] pin_fb_div = '0;
  logic [2:0] pin_div_a = '0;
  logic       pin_div_b = 1'b0;
  logic       pin_prescale = 1'b0;
  logic       lock_in = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_addr = '0;
  logic [7:0] reg_rd_data;
  logic [9:0] act_fb_div;
  logic [2:0] act_div_a;
  logic       act_div_b;
  logic       act_prescale;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pll_divcfg_ctrl u_pll_divcfg_ctrl (
    .clk(clk), .rst(rst), .serial_mode(serial_mode),
    .pin_fb_div(pin_fb_div), .pin_div_a(pin_div_a), .pin_div_b(pin_div_b),
    .pin_prescale(pin_prescale), .lock_in(lock_in),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .act_fb_div(act_fb_div), .act_div_a(act_div_a), .act_div_b(act_div_b),
    .act_prescale(act_prescale)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_rd_addr = a;
    tick();
    d = reg_rd_data;
  endtask

  task automatic chk_act(string req, int fb, int da, int db, int pr);
    chk(req, act_fb_div, fb);
    chk(req, act_div_a, da);
    chk(req, act_div_b, db);
    chk(req, act_prescale, pr);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1; serial_mode = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    chk_act("R1 reset active", 200, 1, 0, 0);
    rd(8'h00, d); chk("R1 reset low byte", d, 8'hC8);
    rd(8'h01, d); chk("R1 reset high byte", d, 8'h04);
  endtask

  task automatic t_pin_mode();
    logic [7:0] d;
    pin_fb_div = 10'h2A5; pin_div_a = 3'd5; pin_div_b = 1'b1; pin_prescale = 1'b0;
    serial_mode = 1'b0;
    tick();
    chk_act("R2 pins to active", 10'h2A5, 5, 1, 0);
    rd(8'h00, d); chk("R3 shadow low mirrors pins", d, 8'hA5);
    rd(8'h01, d); chk("R5 high byte layout", d, 8'h36);
  endtask

  task automatic t_pin_ignore();
    logic [7:0] d;
    wr(8'h00, 8'h11);
    wr(8'hF0, 8'h01);
    wr(8'hF0, 8'h08);
    chk("R3 command ignored", act_fb_div, 10'h2A5);
    rd(8'h00, d); chk("R3 write ignored", d, 8'hA5);
  endtask

  task automatic t_to_host();
    logic [7:0] d;
    serial_mode = 1'b1;
    tick();
    pin_fb_div = 10'd5; pin_div_a = 3'd2; pin_div_b = 1'b0; pin_prescale = 1'b1;
    tick();
    chk_act("R4 active kept", 10'h2A5, 5, 1, 0);
    rd(8'h00, d); chk("R4 shadow kept", d, 8'hA5);
  endtask

  task automatic t_shadow_load();
    logic [7:0] d;
    wr(8'h00, 8'h34);
    wr(8'h01, 8'hFF);
    chk_act("R6 active untouched by writes", 10'h2A5, 5, 1, 0);
    rd(8'h01, d); chk("R5 bit7 write ignored", d, 8'h7F);
    rd(8'h00, d); chk("R6 shadow low written", d, 8'h34);
    wr(8'hF0, 8'h04);
    chk_act("R7 load from shadow", 820, 7, 1, 1);
  endtask

  task automatic t_step_get();
    logic [7:0] d;
    wr(8'hF0, 8'h01);
    chk("R7 inc", act_fb_div, 821);
    rd(8'h00, d); chk("R10 shadow unchanged after inc", d, 8'h34);
    wr(8'hF0, 8'h02);
    wr(8'hF0, 8'h02);
    chk("R7 dec", act_fb_div, 819);
    wr(8'hF0, 8'h08);
    rd(8'h00, d); chk("R10 get copies low", d, 8'h33);
    rd(8'h01, d); chk("R7 get copies high", d, 8'h7F);
  endtask

  task automatic t_saturate();
    wr(8'h00, 8'hFF);
    wr(8'h01, 8'h03);
    wr(8'hF0, 8'h04);
    chk_act("R7 load top", 1023, 0, 0, 0);
    wr(8'hF0, 8'h01);
    chk("R8 inc saturates", act_fb_div, 1023);
    wr(8'h00, 8'h00);
    wr(8'h01, 8'h00);
    wr(8'hF0, 8'h04);
    chk("R7 load zero", act_fb_div, 0);
    wr(8'hF0, 8'h02);
    chk("R8 dec saturates", act_fb_div, 0);
  endtask

  task automatic t_bad_ops();
    logic [7:0] d;
    wr(8'hF0, 8'hA1);
    chk("R7 upper nibble ignored", act_fb_div, 1);
    wr(8'hF0, 8'h05);
    wr(8'hF0, 8'h03);
    wr(8'hF0, 8'h00);
    wr(8'hF0, 8'h0F);
    chk("R9 invalid nibbles", act_fb_div, 1);
    rd(8'hF0, d); chk("R5 command byte reads zero", d, 0);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    lock_in = 1'b1;
    rd(8'h01, d); chk("R5 lock visible", d, 8'h80);
    lock_in = 1'b0;
    rd(8'h01, d); chk("R5 lock clear", d, 8'h00);
  endtask

  task automatic t_back_to_pins();
    logic [7:0] d;
    serial_mode = 1'b0;
    tick();
    chk_act("R2 switch back to pins", 5, 2, 0, 1);
    rd(8'h00, d); chk("R3 shadow follows after switch", d, 8'h05);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pin_mode();
    t_pin_ignore();
    t_to_host();
    t_shadow_load();
    t_step_get();
    t_saturate();
    t_bad_ops();
    t_lock();
    t_back_to_pins();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule